// File: doc/BRIEF.md
# USB Start-of-Frame Capture Unit

This block sits behind a USB receive path that has already removed NRZI coding and bit stuffing and split each token into fields. Each token arrives as a single beat on a valid/ready input carrying an 8-bit packet identifier, 11 frame-number bits and a 5-bit CRC. The unit finds start-of-frame tokens, checks their CRC5 over the frame number, and keeps the most recent frame number in two byte-wide registers (low byte, and a high byte holding the top three bits). It keeps a pair of flags that report whether the last frame token had a valid or a corrupt CRC.

A sticky frame flag and a sticky end-of-reset flag feed a single interrupt line through two enable inputs. Firmware clears each flag with a one-cycle clear pulse. A pulse on the end-of-reset input stands for the end of a bus reset. It sets the end-of-reset flag and returns every other register to its reset value.

Back-pressure rules: `tok_ready` is low while `rst_n` is low, rises on the first clock edge after reset is released, and then stays high. A beat is consumed on each rising edge where `tok_valid` and `tok_ready` are both high. A beat offered while `tok_ready` is low is not consumed and has no effect. The unit never stalls a token, so the source may present a new token on every cycle.

Top module: `usb_sof_capture`

## Requirements
- R1: After reset, `frame_lo`, `frame_hi`, `crc_good`, `crc_bad`, `sof_flag`, `eor_flag` and `irq` are 0, and `tok_ready` is 1 from the first clock edge after `rst_n` is released.
- R2: An accepted beat with `tok_pid` = 8'hA5 sets `sof_flag` at that clock edge. This happens whether the CRC is good or bad.
- R3: On an accepted frame token, `frame_lo` takes frame bits 7:0 and `frame_hi[2:0]` takes frame bits 10:8. `frame_hi[7:3]` always reads 0.
- R4: The CRC check starts from 5'b11111 and uses polynomial x^5+x^2+1. It shifts in frame bits 0 through 10 in that order: feedback = bit XOR remainder[4], the remainder shifts left, and 5'b00101 is XORed in when feedback is 1. The CRC is valid when `tok_crc` equals the bitwise inverse of the final remainder. After each accepted frame token, exactly one of `crc_good` or `crc_bad` is 1, matching that result.
- R5: Every accepted frame token overwrites the frame registers and both CRC flags, even while `sof_flag` is still set from an earlier token.
- R6: `sof_flag` stays 1 until a `clr_sof` pulse. If a frame token is accepted in the same cycle as `clr_sof`, the flag stays set.
- R7: A beat is ignored, with all registers unchanged, when its PID check nibble `tok_pid[7:4]` is not the bitwise inverse of `tok_pid[3:0]`, when it carries any PID other than 8'hA5, or when `tok_valid` is low.
- R8: A `bus_rst_end` pulse sets `eor_flag` and clears the frame registers, `crc_good`, `crc_bad` and `sof_flag`. It takes priority over a frame token accepted in the same cycle. `eor_flag` stays 1 until a `clr_eor` pulse.
- R9: `irq` is 1 exactly when (`sof_flag` AND `sof_ie`) OR (`eor_flag` AND `eor_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token beat valid |
| tok_ready | output | 1 | Unit can accept a token beat |
| tok_pid | input | 8 | Packet identifier with check nibble |
| tok_frame | input | 11 | Frame-number bits |
| tok_crc | input | 5 | Received CRC5 |
| bus_rst_end | input | 1 | One-cycle pulse marking the end of a bus reset |
| clr_sof | input | 1 | Firmware clear pulse for the frame flag |
| clr_eor | input | 1 | Firmware clear pulse for the end-of-reset flag |
| sof_ie | input | 1 | Interrupt enable for the frame flag |
| eor_ie | input | 1 | Interrupt enable for the end-of-reset flag |
| frame_lo | output | 8 | Frame number bits 7:0 |
| frame_hi | output | 8 | Frame number bits 10:8 in bits 2:0, zeros above |
| crc_good | output | 1 | Last frame token had a valid CRC |
| crc_bad | output | 1 | Last frame token had a corrupt CRC |
| sof_flag | output | 1 | Sticky start-of-frame flag |
| eor_flag | output | 1 | Sticky end-of-reset flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends frame numbers whose high bits are all set, so a design that shifted the CRC in the wrong bit order or dropped the inversion would report good tokens as corrupt. A design that forgot to clear the old flag would leave both CRC flags set after a good token follows a bad one. Tokens sent while `sof_flag` is still set must still refresh the frame registers; a design that gated capture on the flag would leave stale numbers. Two cases test precedence: a set and a clear in the same cycle must leave the flag set, and an end-of-reset together with a frame token must win, so a design with the wrong priority would leave a frame number or `sof_flag` behind. Beats with a broken check nibble or an unrelated PID must leave every output unchanged.

// File: rtl/sofc_pkg.sv
package sofc_pkg;
  localparam int PID_W   = 8;
  localparam int FRAME_W = 11;
  localparam int CRC_W   = 5;
  localparam int BYTE_W  = 8;

  localparam logic [PID_W-1:0] SOF_PID  = 8'hA5;
  localparam logic [CRC_W-1:0] CRC_POLY = 5'b00101;
  localparam logic [CRC_W-1:0] CRC_SEED = 5'b11111;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic               crc_ok;
  } sof_capture_t;
endpackage

// File: rtl/sofc_pid_check.sv
module sofc_pid_check #(
  parameter int                PID_W = 8,
  parameter logic [PID_W-1:0]  MATCH = 8'hA5
) (
  input  logic [PID_W-1:0] pid,
  output logic             pid_ok,
  output logic             is_match
);
  localparam int HALF = PID_W / 2;

  logic [HALF-1:0] lo_nib;
  logic [HALF-1:0] hi_nib;

  always_comb begin
    lo_nib   = pid[HALF-1:0];
    hi_nib   = pid[PID_W-1:HALF];
    pid_ok   = (hi_nib == ~lo_nib);
    is_match = pid_ok && (pid == MATCH);
  end
endmodule

// File: rtl/sofc_crc5.sv
module sofc_crc5 #(
  parameter int                DATA_W = 11,
  parameter int                CRC_W  = 5,
  parameter logic [CRC_W-1:0]  POLY   = 5'b00101,
  parameter logic [CRC_W-1:0]  SEED   = 5'b11111
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CRC_W-1:0]  rx_crc,
  output logic              crc_ok
);
  logic [DATA_W:0][CRC_W-1:0] rem;

  assign rem[0] = SEED;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    logic fb;
    assign fb         = data[i] ^ rem[i][CRC_W-1];
    assign rem[i + 1] = {rem[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_ok = (rx_crc == ~rem[DATA_W]);
endmodule

// File: rtl/sofc_regs.sv
module sofc_regs #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_hit,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               crc_ok,
  input  logic               bus_rst_end,
  input  logic               clr_sof,
  input  logic               clr_eor,
  output logic [FRAME_W-1:0] frame_q,
  output logic               good_q,
  output logic               bad_q,
  output logic               sof_q,
  output logic               eor_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      good_q  <= 1'b0;
      bad_q   <= 1'b0;
      sof_q   <= 1'b0;
      eor_q   <= 1'b0;
    end else if (bus_rst_end) begin
      frame_q <= '0;
      good_q  <= 1'b0;
      bad_q   <= 1'b0;
      sof_q   <= 1'b0;
      eor_q   <= 1'b1;
    end else begin
      if (sof_hit) begin
        frame_q <= frame_in;
        good_q  <= crc_ok;
        bad_q   <= !crc_ok;
        sof_q   <= 1'b1;
      end else if (clr_sof) begin
        sof_q   <= 1'b0;
      end
      if (clr_eor) begin
        eor_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usb_sof_capture.sv
module usb_sof_capture
  import sofc_pkg::*;
#(
  parameter int P_PID_W   = PID_W,
  parameter int P_FRAME_W = FRAME_W,
  parameter int P_CRC_W   = CRC_W,
  parameter int P_BYTE_W  = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tok_valid,
  output logic                 tok_ready,
  input  logic [P_PID_W-1:0]   tok_pid,
  input  logic [P_FRAME_W-1:0] tok_frame,
  input  logic [P_CRC_W-1:0]   tok_crc,
  input  logic                 bus_rst_end,
  input  logic                 clr_sof,
  input  logic                 clr_eor,
  input  logic                 sof_ie,
  input  logic                 eor_ie,
  output logic [P_BYTE_W-1:0]  frame_lo,
  output logic [P_BYTE_W-1:0]  frame_hi,
  output logic                 crc_good,
  output logic                 crc_bad,
  output logic                 sof_flag,
  output logic                 eor_flag,
  output logic                 irq
);
  localparam int HI_BITS = P_FRAME_W - P_BYTE_W;

  logic                 rdy_q;
  logic                 pid_ok;
  logic                 pid_sof;
  logic                 crc_ok;
  logic                 sof_hit;
  logic [P_FRAME_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign tok_ready = rdy_q;

  sofc_pid_check #(
    .PID_W (P_PID_W),
    .MATCH (P_PID_W'(SOF_PID))
  ) u_pid (
    .pid      (tok_pid),
    .pid_ok   (pid_ok),
    .is_match (pid_sof)
  );

  sofc_crc5 #(
    .DATA_W (P_FRAME_W),
    .CRC_W  (P_CRC_W),
    .POLY   (P_CRC_W'(CRC_POLY)),
    .SEED   (P_CRC_W'(CRC_SEED))
  ) u_crc (
    .data   (tok_frame),
    .rx_crc (tok_crc),
    .crc_ok (crc_ok)
  );

  assign sof_hit = tok_valid && rdy_q && pid_ok && pid_sof;

  sofc_regs #(
    .FRAME_W (P_FRAME_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_hit     (sof_hit),
    .frame_in    (tok_frame),
    .crc_ok      (crc_ok),
    .bus_rst_end (bus_rst_end),
    .clr_sof     (clr_sof),
    .clr_eor     (clr_eor),
    .frame_q     (frame_q),
    .good_q      (crc_good),
    .bad_q       (crc_bad),
    .sof_q       (sof_flag),
    .eor_q       (eor_flag)
  );

  assign frame_lo = frame_q[P_BYTE_W-1:0];

  if (HI_BITS < P_BYTE_W) begin : g_hi_pad
    assign frame_hi = {{(P_BYTE_W - HI_BITS){1'b0}}, frame_q[P_FRAME_W-1:P_BYTE_W]};
  end else begin : g_hi_full
    assign frame_hi = frame_q[P_BYTE_W +: P_BYTE_W];
  end

  assign irq = (sof_flag && sof_ie) || (eor_flag && eor_ie);
endmodule

// File: rtl/sofc_checker.sv
module sofc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_valid,
  input logic       tok_ready,
  input logic [7:0] tok_pid,
  input logic       bus_rst_end,
  input logic       clr_sof,
  input logic [7:0] frame_lo,
  input logic [7:0] frame_hi,
  input logic       crc_good,
  input logic       crc_bad,
  input logic       sof_flag,
  input logic       eor_flag
);
  logic beat;
  logic sof_beat;
  logic junk_beat;

  assign beat      = tok_valid && tok_ready;
  assign sof_beat  = beat && (tok_pid == 8'hA5);
  assign junk_beat = beat && (tok_pid != 8'hA5);

  AST_ONE_CRC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_good && crc_bad)); // R4

  AST_CRC_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    sof_beat && !bus_rst_end |=> (crc_good || crc_bad)); // R4

  AST_SOF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    sof_beat && !bus_rst_end |=> sof_flag); // R2

  AST_SOF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sof_flag && !clr_sof && !bus_rst_end |=> sof_flag); // R6

  AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hi[7:3] == 5'd0); // R3

  AST_JUNK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    junk_beat && !bus_rst_end && !clr_sof |=>
      $stable(frame_lo) && $stable(frame_hi) && $stable(sof_flag) && $stable(crc_good)); // R7

  AST_EOR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_end |=> eor_flag && !sof_flag && !crc_good && !crc_bad && frame_lo == 8'd0); // R8

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tok_ready |=> tok_ready); // R1
endmodule

bind usb_sof_capture sofc_checker u_sofc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tok_valid   (tok_valid),
  .tok_ready   (tok_ready),
  .tok_pid     (tok_pid),
  .bus_rst_end (bus_rst_end),
  .clr_sof     (clr_sof),
  .frame_lo    (frame_lo),
  .frame_hi    (frame_hi),
  .crc_good    (crc_good),
  .crc_bad     (crc_bad),
  .sof_flag    (sof_flag),
  .eor_flag    (eor_flag)
);

// File: tb/test_usb_sof_capture.sv
module test_usb_sof_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tok_valid;
  logic        tok_ready;
  logic [7:0]  tok_pid;
  logic [10:0] tok_frame;
  logic [4:0]  tok_crc;
  logic        bus_rst_end;
  logic        clr_sof;
  logic        clr_eor;
  logic        sof_ie;
  logic        eor_ie;
  logic [7:0]  frame_lo;
  logic [7:0]  frame_hi;
  logic        crc_good;
  logic        crc_bad;
  logic        sof_flag;
  logic        eor_flag;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  usb_sof_capture i_usb_sof_capture (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_pid(tok_pid), .tok_frame(tok_frame), .tok_crc(tok_crc),
    .bus_rst_end(bus_rst_end), .clr_sof(clr_sof), .clr_eor(clr_eor),
    .sof_ie(sof_ie), .eor_ie(eor_ie), .frame_lo(frame_lo), .frame_hi(frame_hi),
    .crc_good(crc_good), .crc_bad(crc_bad), .sof_flag(sof_flag),
    .eor_flag(eor_flag), .irq(irq)
  );

  function automatic logic [4:0] good_crc(input logic [10:0] f);
    logic [4:0] r = 5'b11111;
    for (int i = 0; i < 11; i++) begin
      logic fb = f[i] ^ r[4];
      r = {r[3:0], 1'b0};
      if (fb) r = r ^ 5'b00101;
    end
    return ~r;
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic check_frame(input logic [10:0] f, input string tag);
    chk(frame_lo, f[7:0], {tag, " frame_lo"});
    chk(frame_hi, {5'd0, f[10:8]}, {tag, " frame_hi"});
  endtask

  // one beat; optional end-of-reset and clear pulses in the same cycle
  task automatic beat(input logic [7:0] pid, input logic [10:0] f, input logic [4:0] c,
                      input logic v, input logic eor, input logic cs);
    @(negedge clk);
    tok_valid = v; tok_pid = pid; tok_frame = f; tok_crc = c;
    bus_rst_end = eor; clr_sof = cs;
    @(negedge clk);
    tok_valid = 1'b0; bus_rst_end = 1'b0; clr_sof = 1'b0;
  endtask

  task automatic pulse_clr(input logic s, input logic e);
    @(negedge clk);
    clr_sof = s; clr_eor = e;
    @(negedge clk);
    clr_sof = 1'b0; clr_eor = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tok_ready, 0, "R1 ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(tok_ready, 1, "R1 ready after reset");
    chk({frame_lo, frame_hi}, 0, "R1 frame regs");
    chk({crc_good, crc_bad, sof_flag, eor_flag, irq}, 0, "R1 flags");
  endtask

  task automatic t_good_sof();
    beat(8'hA5, 11'h7FF, good_crc(11'h7FF), 1, 0, 0);
    chk(sof_flag, 1, "R2 flag set");
    check_frame(11'h7FF, "R3");
    chk({crc_good, crc_bad}, 2'b10, "R4 good crc all ones");
    pulse_clr(1, 0);
    beat(8'hA5, 11'h523, good_crc(11'h523), 1, 0, 0);
    check_frame(11'h523, "R3 pattern");
    chk({crc_good, crc_bad}, 2'b10, "R4 good crc 523");
  endtask

  task automatic t_bad_crc_then_good();
    beat(8'hA5, 11'h0F0, good_crc(11'h0F0) ^ 5'h01, 1, 0, 0);
    chk({crc_good, crc_bad}, 2'b01, "R4 corrupt crc");
    chk(sof_flag, 1, "R2 flag on corrupt token");
    check_frame(11'h0F0, "R3 corrupt capture");
    beat(8'hA5, 11'h400, good_crc(11'h400), 1, 0, 0);
    chk({crc_good, crc_bad}, 2'b10, "R5 crc flags refreshed");
    check_frame(11'h400, "R5 frame overwritten while flag set");
  endtask

  task automatic t_sticky_and_clear();
    repeat (3) @(negedge clk);
    chk(sof_flag, 1, "R6 flag sticky");
    pulse_clr(1, 0);
    chk(sof_flag, 0, "R6 clear pulse");
    beat(8'hA5, 11'h0AA, good_crc(11'h0AA), 1, 0, 1);
    chk(sof_flag, 1, "R6 set beats clear");
  endtask

  task automatic t_ignored();
    pulse_clr(1, 0);
    beat(8'hA4, 11'h155, good_crc(11'h155), 1, 0, 0);
    chk(sof_flag, 0, "R7 bad check nibble flag");
    check_frame(11'h0AA, "R7 bad check nibble frame");
    beat(8'hE1, 11'h155, good_crc(11'h155), 1, 0, 0);
    chk(sof_flag, 0, "R7 other pid flag");
    check_frame(11'h0AA, "R7 other pid frame");
    beat(8'hA5, 11'h155, good_crc(11'h155), 0, 0, 0);
    chk(sof_flag, 0, "R7 valid low flag");
    chk({crc_good, crc_bad}, 2'b10, "R7 crc flags held");
  endtask

  task automatic t_eor();
    beat(8'hA5, 11'h3C3, good_crc(11'h3C3) ^ 5'h10, 1, 0, 0);
    beat(8'h00, 11'h000, 5'h00, 0, 1, 0);
    chk(eor_flag, 1, "R8 eor set");
    chk({crc_good, crc_bad, sof_flag}, 0, "R8 flags cleared");
    check_frame(11'h000, "R8 frame cleared");
    repeat (2) @(negedge clk);
    chk(eor_flag, 1, "R8 eor sticky");
    pulse_clr(0, 1);
    chk(eor_flag, 0, "R8 eor cleared");
    beat(8'hA5, 11'h2B7, good_crc(11'h2B7), 1, 1, 0);
    chk({eor_flag, sof_flag}, 2'b10, "R8 eor wins over token");
    check_frame(11'h000, "R8 token dropped");
    pulse_clr(0, 1);
  endtask

  task automatic t_irq();
    sof_ie = 1'b0; eor_ie = 1'b0;
    beat(8'hA5, 11'h011, good_crc(11'h011), 1, 0, 0);
    chk(irq, 0, "R9 sof masked");
    sof_ie = 1'b1; #1;
    chk(irq, 1, "R9 sof enabled");
    pulse_clr(1, 0);
    chk(irq, 0, "R9 after sof clear");
    beat(8'h00, 11'h000, 5'h00, 0, 1, 0);
    chk(irq, 0, "R9 eor masked");
    eor_ie = 1'b1; #1;
    chk(irq, 1, "R9 eor enabled");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hang, expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tok_valid = 1'b0; tok_pid = 8'h00; tok_frame = '0; tok_crc = '0;
    bus_rst_end = 1'b0; clr_sof = 1'b0; clr_eor = 1'b0; sof_ie = 1'b0; eor_ie = 1'b0;
    t_reset();
    t_good_sof();
    t_bad_crc_then_good();
    t_sticky_and_clear();
    t_ignored();
    t_eor();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule